// File: doc/BRIEF.md
# Multi-Mode 8-bit Timer with Waveform Output

This block is a tick-driven counter with one compare register and one waveform output. A control register picks one of four counting modes. The first is a free-running count. The second restarts the count when it reaches the compare value. The third is a single-slope PWM that wraps from the maximum back to zero. The fourth is a dual-slope PWM that counts up to the maximum and then back down to zero. In each mode the compare-output code in the control register decides what a compare match does to the output. It can toggle, clear or set the output, or leave it untouched. In the PWM modes the output is also driven to a fixed level at the wrap point.

The counter moves only on cycles where the count-enable tick is high, so an outside prescaler or edge detector picks the rate. Software writes the control, count and compare registers through separate write strobes. Setting the top bit of a control write forces a compare action without a real match. The block reports a one-cycle compare-match event and a one-cycle overflow event, and raises an output-enable signal whenever the waveform should own the pin. All pins are plain level or pulse signals with no handshake. A write is accepted in the cycle its strobe is high and is never stalled. The events are single-cycle pulses that the consumer must catch in the cycle they appear.

Top module: `cwt_timer`

## Requirements
- R1: After reset the control register, the count, the compare register, the waveform output, the output enable and both events are all zero.
- R2: In mode 0 (control bit 3 = 0, bit 6 = 0) each tick adds one and the count wraps from 0xFF to 0x00. The overflow event pulses on the cycle after the tick taken at 0xFF. The match event pulses on the cycle after a tick taken while the count equals the compare value. Without a tick the count holds.
- R3: In mode 2 (bit 3 = 1, bit 6 = 0) a tick taken at the compare value returns the count to zero. With a compare value of N the count therefore cycles through 0..N, with one match every N+1 ticks.
- R4: In modes 0 and 2, compare-output code (control bits 5:4) 01 toggles the output on a match, 10 clears it, 11 sets it, and 00 leaves it alone.
- R5: In mode 3 (bit 3 = 1, bit 6 = 1), code 10 clears the output on a match and sets it at the wrap to zero, so it is high for C+1 of every 256 ticks. Code 11 gives the inverse, 255-C high ticks.
- R6: In mode 1 (bit 3 = 0, bit 6 = 1) the count runs 0 up to 0xFF and back down over a 510-tick period. The overflow event fires where the count turns at zero. Code 10 clears on an up-count match and sets on a down-count match, giving 2C high ticks; code 11 gives 510-2C.
- R7: In modes 0 and 2 a compare write takes effect for the very next tick. In the PWM modes it takes effect only after the count passes 0xFF.
- R8: A control write with bit 7 set applies the action of the written code in modes 0 and 2. It raises no match event and leaves the count unchanged. In the PWM modes it has no effect.
- R9: A count write loads the value, and the next tick performs no compare match even when the loaded value equals the compare value.
- R10: The output enable is high when the code is nonzero, except for code 01 in a PWM mode, which is reserved and treated as disconnected.
- R11: The control register reads back what was written, with bit 7 always read as zero. Bits 2:0 are stored but do not affect this block.
- R12: In a PWM mode with a compare value of 0xFF and code bit 5 set, the match is ignored and raises no event. The output then stays high for code 10 and low for code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable for this cycle |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data (bit 7 = force strobe) |
| cnt_we_i | input | 1 | Count register write strobe |
| cnt_wdata_i | input | W | Count write data |
| cmp_we_i | input | 1 | Compare register write strobe |
| cmp_wdata_i | input | W | Compare write data |
| ctrl_o | output | 8 | Control register readback |
| cnt_o | output | W | Current count |
| cmp_o | output | W | Compare register readback (last written value) |
| wave_o | output | 1 | Waveform output |
| wave_oe_o | output | 1 | Output enable (waveform owns the pin) |
| match_o | output | 1 | One-cycle compare-match event |
| ovf_o | output | 1 | One-cycle overflow event |

## Verification
Every result is registered, so the count, the waveform level and both events change exactly one clock after the edge that sampled the tick or the write. The bench drives all inputs on the falling edge and reads the results on the next falling edge, half a cycle after they update. The PWM duty values only hold once the buffered compare value has moved in, which can take up to one full period. For that reason the bench first lets more than one period run, then counts the high cycles over exactly one 256-tick or 510-tick period and compares them with the closed-form figure for that compare value and code.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_PHASE = 2'd1,
    MODE_CTC   = 2'd2,
    MODE_FAST  = 2'd3
  } cwt_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } cwt_act_e;

  localparam int CTRL_W    = 8;
  localparam int FORCE_BIT = 7;
  localparam int MODE0_BIT = 6;
  localparam int CODE_HI   = 5;
  localparam int CODE_LO   = 4;
  localparam int MODE1_BIT = 3;

  function automatic cwt_mode_e mode_of(input logic [CTRL_W-1:0] c);
    return cwt_mode_e'({c[MODE1_BIT], c[MODE0_BIT]});
  endfunction

  function automatic logic is_pwm(input cwt_mode_e m);
    return (m == MODE_PHASE) || (m == MODE_FAST);
  endfunction

endpackage

// File: rtl/cwt_ctrl_reg.sv
module cwt_ctrl_reg
  import cwt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output cwt_mode_e         mode_o,
  output logic [1:0]        code_o,
  output logic              force_o,
  output logic [1:0]        force_code_o
);

  logic [CTRL_W-2:0] stored_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stored_q <= '0;
    end else if (we_i) begin
      stored_q <= wdata_i[CTRL_W-2:0];
    end
  end

  // The strobe bit is never stored, so it reads back as zero.
  assign ctrl_o       = {1'b0, stored_q};
  assign mode_o       = mode_of(ctrl_o);
  assign code_o       = ctrl_o[CODE_HI:CODE_LO];
  // Force is judged on the mode being written in the same access.
  assign force_o      = we_i && wdata_i[FORCE_BIT] && !is_pwm(mode_of(wdata_i));
  assign force_code_o = wdata_i[CODE_HI:CODE_LO];

endmodule

// File: rtl/cwt_counter.sv
module cwt_counter
  import cwt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  cwt_mode_e    mode_i,
  input  logic [W-1:0] cmp_act_i,
  output logic [W-1:0] cnt_o,
  output logic         at_max_o,
  output logic         up_phase_o,
  output logic         blocked_o,
  output logic         ovf_ev_o
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_nxt;
  logic         dir_up_q, dir_up_nxt;
  logic         block_q;
  logic         at_zero;

  assign at_zero  = (cnt_q == '0);
  assign at_max_o = (cnt_q == MAXV);

  always_comb begin
    cnt_nxt    = cnt_q + ONE;
    dir_up_nxt = 1'b1;
    unique case (mode_i)
      MODE_CTC: begin
        if (cnt_q == cmp_act_i) cnt_nxt = '0;
      end
      MODE_PHASE: begin
        dir_up_nxt = dir_up_q;
        if (dir_up_q) begin
          if (at_max_o) begin
            cnt_nxt    = cnt_q - ONE;
            dir_up_nxt = 1'b0;
          end
        end else if (at_zero) begin
          dir_up_nxt = 1'b1;
        end else begin
          cnt_nxt = cnt_q - ONE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b1;
      block_q  <= 1'b0;
    end else begin
      if (load_i) begin
        cnt_q   <= load_val_i;
        block_q <= 1'b1;
      end else if (step_i) begin
        cnt_q   <= cnt_nxt;
        block_q <= 1'b0;
      end
      if (mode_i != MODE_PHASE) begin
        dir_up_q <= 1'b1;
      end else if (step_i && !load_i) begin
        dir_up_q <= dir_up_nxt;
      end
    end
  end

  // A match counts as up-counting when the next step moves upward.
  assign up_phase_o = (mode_i != MODE_PHASE) || at_zero || (dir_up_q && !at_max_o);
  assign blocked_o  = block_q;
  assign cnt_o      = cnt_q;
  assign ovf_ev_o   = step_i && ((mode_i == MODE_PHASE) ? (!dir_up_q && at_zero) : at_max_o);

endmodule

// File: rtl/cwt_compare.sv
module cwt_compare
  import cwt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  cwt_mode_e    mode_i,
  input  logic         upd_pt_i,
  output logic [W-1:0] cmp_buf_o,
  output logic [W-1:0] cmp_act_o
);

  logic [W-1:0] buf_q, act_q, incoming;

  assign incoming = we_i ? wdata_i : buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (we_i) buf_q <= wdata_i;
      // Non-PWM: the active value follows writes at once.
      // PWM: it moves only at the update point after 0xFF.
      if (!is_pwm(mode_i) || upd_pt_i) act_q <= incoming;
    end
  end

  assign cmp_buf_o = buf_q;
  assign cmp_act_o = act_q;

endmodule

// File: rtl/cwt_wave.sv
module cwt_wave
  import cwt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cwt_mode_e  mode_i,
  input  logic [1:0] code_i,
  input  logic       step_i,
  input  logic       at_max_i,
  input  logic       match_ev_i,
  input  logic       up_phase_i,
  input  logic       top_special_i,
  input  logic       force_i,
  input  logic [1:0] force_code_i,
  output logic       wave_o
);

  cwt_act_e act;
  logic     wave_q;
  logic     noninv;

  assign noninv = (code_i == 2'b10);

  always_comb begin
    act = ACT_NONE;
    if (force_i) begin
      act = cwt_act_e'(force_code_i);
    end else begin
      unique case (mode_i)
        MODE_FREE, MODE_CTC: begin
          if (match_ev_i) act = cwt_act_e'(code_i);
        end
        MODE_FAST: begin
          if (code_i[1]) begin
            if (step_i && at_max_i)  act = noninv ? ACT_SET : ACT_CLEAR;
            else if (match_ev_i)     act = noninv ? ACT_CLEAR : ACT_SET;
          end
        end
        MODE_PHASE: begin
          if (code_i[1]) begin
            if (step_i && at_max_i && top_special_i) act = noninv ? ACT_SET : ACT_CLEAR;
            else if (match_ev_i) begin
              if (up_phase_i) act = noninv ? ACT_CLEAR : ACT_SET;
              else            act = noninv ? ACT_SET : ACT_CLEAR;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_TOGGLE: wave_q <= !wave_q;
        ACT_CLEAR:  wave_q <= 1'b0;
        ACT_SET:    wave_q <= 1'b1;
        default:    ;
      endcase
    end
  end

  assign wave_o = wave_q;

endmodule

// File: rtl/cwt_timer.sv
module cwt_timer
  import cwt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              cnt_we_i,
  input  logic [W-1:0]      cnt_wdata_i,
  input  logic              cmp_we_i,
  input  logic [W-1:0]      cmp_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [W-1:0]      cnt_o,
  output logic [W-1:0]      cmp_o,
  output logic              wave_o,
  output logic              wave_oe_o,
  output logic              match_o,
  output logic              ovf_o
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  cwt_mode_e    mode;
  logic [1:0]   code, force_code;
  logic         force_stb;
  logic         step;
  logic [W-1:0] cnt, cmp_act;
  logic         at_max, up_phase, blocked, ovf_ev;
  logic         top_special, match_ev;
  logic         match_q, ovf_q;

  // A count write wins over a tick in the same cycle.
  assign step = tick_i && !cnt_we_i;

  cwt_ctrl_reg u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (ctrl_we_i),
    .wdata_i      (ctrl_wdata_i),
    .ctrl_o       (ctrl_o),
    .mode_o       (mode),
    .code_o       (code),
    .force_o      (force_stb),
    .force_code_o (force_code)
  );

  cwt_counter #(.W(W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .load_i     (cnt_we_i),
    .load_val_i (cnt_wdata_i),
    .mode_i     (mode),
    .cmp_act_i  (cmp_act),
    .cnt_o      (cnt),
    .at_max_o   (at_max),
    .up_phase_o (up_phase),
    .blocked_o  (blocked),
    .ovf_ev_o   (ovf_ev)
  );

  // The buffer update point is the step taken at 0xFF in both PWM modes:
  // the top of the dual slope, and the wrap to the bottom for single slope.
  cwt_compare #(.W(W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cmp_we_i),
    .wdata_i   (cmp_wdata_i),
    .mode_i    (mode),
    .upd_pt_i  (step && at_max),
    .cmp_buf_o (cmp_o),
    .cmp_act_o (cmp_act)
  );

  assign top_special = (cmp_act == MAXV) && code[1];
  assign match_ev    = step && (cnt == cmp_act) && !blocked &&
                       !(is_pwm(mode) && top_special);

  cwt_wave u_wave (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode),
    .code_i        (code),
    .step_i        (step),
    .at_max_i      (at_max),
    .match_ev_i    (match_ev),
    .up_phase_i    (up_phase),
    .top_special_i (top_special),
    .force_i       (force_stb),
    .force_code_i  (force_code),
    .wave_o        (wave_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      match_q <= match_ev;
      ovf_q   <= ovf_ev;
    end
  end

  assign cnt_o     = cnt;
  assign match_o   = match_q;
  assign ovf_o     = ovf_q;
  assign wave_oe_o = (code != 2'b00) && !(is_pwm(mode) && code == 2'b01);

endmodule

// File: rtl/cwt_checker.sv
module cwt_checker #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         ctrl_we_i,
  input logic [7:0]   ctrl_wdata_i,
  input logic         cnt_we_i,
  input logic [W-1:0] cnt_wdata_i,
  input logic [7:0]   ctrl_o,
  input logic [W-1:0] cnt_o,
  input logic         wave_oe_o,
  input logic         match_o,
  input logic         ovf_o
);

  a_r9_write_blocks_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (!match_o && cnt_o == $past(cnt_wdata_i)));

  a_r8_force_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[7] && !tick_i) |=> !match_o);

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_we_i) |=> $stable(cnt_o));

  a_r2_ovf_lands_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && {$past(ctrl_o[3]), $past(ctrl_o[6])} != 2'b01) |-> (cnt_o == '0));

  a_r6_ovf_turns_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && {$past(ctrl_o[3]), $past(ctrl_o[6])} == 2'b01) |-> (cnt_o == 1));

  a_r10_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[5:4] == 2'b00) |-> !wave_oe_o);

endmodule

bind cwt_timer cwt_checker #(.W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .cnt_we_i     (cnt_we_i),
  .cnt_wdata_i  (cnt_wdata_i),
  .ctrl_o       (ctrl_o),
  .cnt_o        (cnt_o),
  .wave_oe_o    (wave_oe_o),
  .match_o      (match_o),
  .ovf_o        (ovf_o)
);

// File: tb/cwt_timer_tb_top.sv
`timescale 1ns/1ps
module cwt_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ctrl_we = 1'b0, cnt_we = 1'b0, cmp_we = 1'b0;
  logic [7:0] ctrl_wd = '0, cnt_wd = '0, cmp_wd = '0;
  logic [7:0] ctrl_q, cnt_q, cmp_q;
  logic       wave, oe, match, ovf;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  cwt_timer #(.W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd),
    .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wd),
    .ctrl_o(ctrl_q), .cnt_o(cnt_q), .cmp_o(cmp_q),
    .wave_o(wave), .wave_oe_o(oe), .match_o(match), .ovf_o(ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wd = v;
    @(posedge clk); @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_we = 1'b1; cnt_wd = v;
    @(posedge clk); @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic wr_cmp(input logic [7:0] v);
    cmp_we = 1'b1; cmp_wd = v;
    @(posedge clk); @(negedge clk);
    cmp_we = 1'b0;
  endtask

  task automatic run(input int n, input int every,
                     output int hi, output int nm, output int nov, output int mx);
    hi = 0; nm = 0; nov = 0; mx = 0;
    for (int i = 0; i < n; i++) begin
      tick = ((i % every) == 0);
      @(posedge clk); @(negedge clk);
      hi  += int'(wave);
      nm  += int'(match);
      nov += int'(ovf);
      if (int'(cnt_q) > mx) mx = int'(cnt_q);
    end
    tick = 1'b0;
  endtask

  task automatic run_to_match(output int cnt_at);
    cnt_at = -1;
    for (int i = 0; i < 600; i++) begin
      tick = 1'b1;
      @(posedge clk); @(negedge clk);
      if (match) begin
        cnt_at = int'(cnt_q);
        break;
      end
    end
    tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi, nm, nov, mx, at;
    int ocrs[6] = '{0, 1, 7, 128, 254, 255};
    logic w0;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ctrl", ctrl_q, 0);  check("R1 cnt", cnt_q, 0);
    check("R1 cmp", cmp_q, 0);    check("R1 wave", wave, 0);
    check("R1 oe", oe, 0);        check("R1 match", match, 0);
    check("R1 ovf", ovf, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8/R11: force in mode 0 with set code; bit 7 reads zero
    wr_ctrl(8'hB5);
    check("R11 readback", ctrl_q, 8'h35);
    check("R8 force sets", wave, 1);
    check("R8 force no match", match, 0);
    check("R8 force no count", cnt_q, 0);
    check("R10 oe set code", oe, 1);

    // R2 free-running
    wr_ctrl(8'h01); wr_cmp(8'h40); wr_cnt(8'h00);
    run(512, 1, hi, nm, nov, mx);
    check("R2 matches", nm, 2); check("R2 ovfs", nov, 2); check("R2 wrap", cnt_q, 0);
    check("R2 idle wave", wave, 1);
    run(20, 2, hi, nm, nov, mx);
    check("R2 gated ticks", cnt_q, 10);

    // R3 clear on compare
    wr_ctrl(8'h08); wr_cmp(8'd9); wr_cnt(8'h00);
    run(100, 1, hi, nm, nov, mx);
    check("R3 matches", nm, 10); check("R3 no ovf", nov, 0);
    check("R3 peak", mx, 9);     check("R3 end", cnt_q, 0);

    // R4 non-PWM codes
    wr_ctrl(8'h10); wr_cmp(8'd5); wr_cnt(8'h00);
    run(256, 1, hi, nm, nov, mx); check("R4 toggle a", wave, 0);
    run(256, 1, hi, nm, nov, mx); check("R4 toggle b", wave, 1);
    wr_ctrl(8'h20); run(256, 1, hi, nm, nov, mx); check("R4 clear", wave, 0);
    wr_ctrl(8'h30); run(256, 1, hi, nm, nov, mx); check("R4 set", wave, 1);

    // R9 count write blocks next compare
    wr_ctrl(8'h10); wr_cmp(8'h30); wr_cnt(8'h30);
    run(1, 1, hi, nm, nov, mx);
    check("R9 blocked match", nm, 0); check("R9 counted", cnt_q, 8'h31);
    check("R9 wave kept", wave, 1);
    wr_cnt(8'h2F);
    run(2, 1, hi, nm, nov, mx);
    check("R9 match resumes", nm, 1);

    // R8 force in CTC: toggles, no clear, no event
    wr_ctrl(8'h18); wr_cmp(8'd50); wr_cnt(8'd20);
    w0 = wave;
    wr_ctrl(8'h98);
    check("R8 ctc toggle", wave, int'(!w0));
    check("R8 ctc no clear", cnt_q, 20);
    check("R8 ctc no match", match, 0);
    check("R11 ctrl after force", ctrl_q, 8'h18);

    // R8 force ignored in fast PWM
    wr_ctrl(8'h68);
    w0 = wave;
    wr_ctrl(8'hE8);
    check("R8 pwm force ignored", wave, int'(w0));

    // R5/R12 fast PWM sweep
    for (int k = 0; k < 6; k++) begin
      for (int c = 2; c < 4; c++) begin
        wr_ctrl(8'h48 | 8'(c << 4)); wr_cmp(8'(ocrs[k]));
        run(600, 1, hi, nm, nov, mx);
        run(256, 1, hi, nm, nov, mx);
        check($sformatf("R5 fast hi ocr=%0d code=%0d", ocrs[k], c), hi,
              (c == 2) ? ocrs[k] + 1 : 255 - ocrs[k]);
        check($sformatf("R12 fast match ocr=%0d", ocrs[k]), nm, (ocrs[k] == 255) ? 0 : 1);
        check("R5 fast ovf", nov, 1);
      end
    end

    // R6/R12 phase-correct sweep
    for (int k = 0; k < 6; k++) begin
      for (int c = 2; c < 4; c++) begin
        wr_ctrl(8'h40 | 8'(c << 4)); wr_cmp(8'(ocrs[k]));
        run(1100, 1, hi, nm, nov, mx);
        run(510, 1, hi, nm, nov, mx);
        check($sformatf("R6 phase hi ocr=%0d code=%0d", ocrs[k], c), hi,
              (c == 2) ? 2 * ocrs[k] : 510 - 2 * ocrs[k]);
        check($sformatf("R12 phase match ocr=%0d", ocrs[k]), nm,
              (ocrs[k] == 255) ? 0 : ((ocrs[k] == 0) ? 1 : 2));
        check("R6 phase ovf", nov, 1);
      end
    end

    // R7 buffered vs immediate compare update
    wr_ctrl(8'h48); wr_cmp(8'd100);
    run(600, 1, hi, nm, nov, mx);
    wr_cnt(8'd10); wr_cmp(8'd20);
    run_to_match(at); check("R7 fast keeps old", at, 101);
    run_to_match(at); check("R7 fast new after wrap", at, 21);
    wr_ctrl(8'h00); wr_cmp(8'd100); wr_cnt(8'd10); wr_cmp(8'd20);
    run_to_match(at); check("R7 free immediate", at, 21);

    // R10 output enable
    wr_ctrl(8'h58); check("R10 fast code01 off", oe, 0);
    wr_ctrl(8'h50); check("R10 phase code01 off", oe, 0);
    wr_ctrl(8'h10); check("R10 free code01 on", oe, 1);
    wr_ctrl(8'h68); check("R10 fast code10 on", oe, 1);
    wr_ctrl(8'h00); check("R10 code00 off", oe, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule